// File: doc/BRIEF.md
# Karatsuba Carry-Less Field Multiplier

This block multiplies two 128-bit elements of GF(2^128) given in the bit-reflected, byte-reversed form that software carry-less hash kernels use internally. Each operand is cut into two 64-bit halves. Three 64x64 carry-less products are formed: low times low, high times high, and the XOR of the halves times the XOR of the halves. Their sum makes the 256-bit unreduced product. A fixed two-phase network of lane shifts and XORs then folds that product down to 128 bits.

The unit is fully pipelined. A one-cycle start pulse samples both operands, and a one-cycle done pulse marks the result five cycles later. A new start may be issued in every cycle. The 256-bit unreduced product is presented together with the reduced result. A neighbouring block can XOR several such products and reduce only once.

Top module: `gfm_karatsuba_mul`

## Requirements
- R1: While reset is held and after it is released with no start, done_o is 0 and res_o and prod_o are all zeros.
- R2: a_i and b_i are sampled only in a cycle where start_i is 1. Values on them in the following cycles do not change that operation's result.
- R3: A start in cycle n gives done_o = 1 for exactly cycle n+5. done_o is 0 in every cycle that does not follow a start by five cycles.
- R4: When done_o is 1, prod_o holds the 256-bit carry-less product of the sampled operands, with bit i being the coefficient of x^i. Bit 255 is always 0.
- R5: When done_o is 1, res_o equals a·b·x^-128 mod (x^128 + x^127 + x^126 + x^121 + 1), with bit i of each operand being the coefficient of x^i.
- R6: If either operand is zero, res_o and prod_o are zero.
- R7: With b_i = 0xC2000000_00000000_00000000_00000001 (the residue of x^128), res_o equals a_i for every a_i.
- R8: Starts on consecutive cycles give results in issue order, one per cycle, each correct.
- R9: res_o and prod_o keep their values in every cycle where done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Samples a_i and b_i this cycle |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand, typically the hash key |
| done_o | output | 1 | One-cycle pulse: res_o and prod_o are valid |
| res_o | output | 128 | Reduced field product |
| prod_o | output | 256 | Unreduced carry-less product |

## Verification
The hardest behaviour to reach is a reduction where the phase-one fold term has bits in both 64-bit lanes. In that case the carried term and the cross-lane losses of the right shifts must cancel exactly. Sweeping a single set bit through all 128 positions of a_i against the x^128 residue makes each reduction bit take part alone, with an exact expected value. Random pairs and back-to-back issue with the inputs scrambled after each start cover the combined cases and the pipeline ordering.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int GF_W     = 128;
  localparam int HALF_W   = GF_W / 2;
  localparam int PROD_W   = 2 * GF_W;
  localparam int HPROD_W  = 2 * HALF_W - 1;
  localparam int PIPE_LAT = 5;
  // lane shift amounts of the two reduction phases
  localparam int FOLD_SH0 = 63;
  localparam int FOLD_SH1 = 62;
  localparam int FOLD_SH2 = 57;
  localparam int NUM_SR   = 3;

  typedef logic [GF_W-1:0]    gf_elem_t;
  typedef logic [PROD_W-1:0]  gf_wide_t;
  typedef logic [HPROD_W-1:0] gf_half_prod_t;

  typedef struct packed {
    gf_elem_t              hi;
    gf_elem_t              lo_fold;
    logic [HALF_W-1:0]     carry;
  } fold_state_t;
endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int N = 64
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-2:0] p_o
);
  localparam int PW = 2 * N - 1;
  logic [PW-1:0] x_ext;

  assign x_ext = {{(N-1){1'b0}}, x_i};

  always_comb begin
    p_o = '0;
    for (int i = 0; i < N; i++) begin
      if (y_i[i]) p_o = p_o ^ (x_ext << i);
    end
  end
endmodule

// File: rtl/gfm_kara_mults.sv
module gfm_kara_mults
  import gfm_pkg::*;
(
  input  gf_elem_t      a_i,
  input  gf_elem_t      b_i,
  output gf_half_prod_t ll_o,
  output gf_half_prod_t hh_o,
  output gf_half_prod_t mm_o
);
  logic [HALF_W-1:0] xa [3];
  logic [HALF_W-1:0] xb [3];
  gf_half_prod_t     pr [3];

  assign xa[0] = a_i[HALF_W-1:0];
  assign xb[0] = b_i[HALF_W-1:0];
  assign xa[1] = a_i[GF_W-1:HALF_W];
  assign xb[1] = b_i[GF_W-1:HALF_W];
  assign xa[2] = a_i[HALF_W-1:0] ^ a_i[GF_W-1:HALF_W];
  assign xb[2] = b_i[HALF_W-1:0] ^ b_i[GF_W-1:HALF_W];

  for (genvar g = 0; g < 3; g++) begin : g_mul
    gfm_clmul #(.N(HALF_W)) mul_i (
      .x_i(xa[g]),
      .y_i(xb[g]),
      .p_o(pr[g])
    );
  end

  assign ll_o = pr[0];
  assign hh_o = pr[1];
  assign mm_o = pr[2];
endmodule

// File: rtl/gfm_fold.sv
module gfm_fold
  import gfm_pkg::*;
(
  input  gf_wide_t    wide_i,
  output fold_state_t st_o
);
  logic [HALF_W-1:0] l0, l1, f0, f1;

  assign l0 = wide_i[HALF_W-1:0];
  assign l1 = wide_i[GF_W-1:HALF_W];
  assign f0 = (l0 << FOLD_SH0) ^ (l0 << FOLD_SH1) ^ (l0 << FOLD_SH2);
  assign f1 = (l1 << FOLD_SH0) ^ (l1 << FOLD_SH1) ^ (l1 << FOLD_SH2);

  assign st_o.hi      = wide_i[PROD_W-1:GF_W];
  assign st_o.lo_fold = {l1 ^ f0, l0};
  assign st_o.carry   = f1;
endmodule

// File: rtl/gfm_finish.sv
module gfm_finish
  import gfm_pkg::*;
(
  input  fold_state_t st_i,
  output gf_elem_t    res_o
);
  localparam int SR_AMT [NUM_SR] = '{1, 2, 7};

  gf_elem_t x;
  gf_elem_t sh [NUM_SR];

  assign x = st_i.lo_fold;

  for (genvar g = 0; g < NUM_SR; g++) begin : g_sr
    assign sh[g] = {x[GF_W-1:HALF_W] >> SR_AMT[g], x[HALF_W-1:0] >> SR_AMT[g]};
  end

  always_comb begin
    res_o = st_i.hi ^ x ^ {{HALF_W{1'b0}}, st_i.carry};
    for (int k = 0; k < NUM_SR; k++) res_o = res_o ^ sh[k];
  end
endmodule

// File: rtl/gfm_karatsuba_mul.sv
module gfm_karatsuba_mul
  import gfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [GF_W-1:0]   a_i,
  input  logic [GF_W-1:0]   b_i,
  output logic              done_o,
  output logic [GF_W-1:0]   res_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [PIPE_LAT-1:0] vld_q;
  gf_elem_t            opa_q, opb_q;
  gf_half_prod_t       ll_c, hh_c, mm_c, ll_q, hh_q, mm_q;
  gf_half_prod_t       mid_c;
  gf_elem_t            lo_c, hi_c;
  gf_wide_t            wide_q, wide4_q;
  fold_state_t         fold_c, fold_q;
  gf_elem_t            fin_c;
  gf_elem_t            res_q;
  gf_wide_t            prod_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[PIPE_LAT-2:0], start_i};
  end

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (start_i) begin
      opa_q <= a_i;
      opb_q <= b_i;
    end
  end

  // stage 2: three half-width products
  gfm_kara_mults mults_i (
    .a_i (opa_q),
    .b_i (opb_q),
    .ll_o(ll_c),
    .hh_o(hh_c),
    .mm_o(mm_c)
  );

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      ll_q <= ll_c;
      hh_q <= hh_c;
      mm_q <= mm_c;
    end
  end

  // stage 3: recombine into the unreduced product
  assign mid_c = mm_q ^ ll_q ^ hh_q;
  assign lo_c  = {1'b0, ll_q} ^ {mid_c[HALF_W-1:0], {HALF_W{1'b0}}};
  assign hi_c  = {1'b0, hh_q} ^ {{(HALF_W+1){1'b0}}, mid_c[HPROD_W-1:HALF_W]};

  always_ff @(posedge clk) begin
    if (vld_q[1]) wide_q <= {hi_c, lo_c};
  end

  // stage 4: first reduction phase
  gfm_fold fold_i (
    .wide_i(wide_q),
    .st_o  (fold_c)
  );

  always_ff @(posedge clk) begin
    if (vld_q[2]) begin
      fold_q  <= fold_c;
      wide4_q <= wide_q;
    end
  end

  // stage 5: second reduction phase, registered outputs
  gfm_finish finish_i (
    .st_i (fold_q),
    .res_o(fin_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      prod_q <= '0;
    end else if (vld_q[3]) begin
      res_q  <= fin_c;
      prod_q <= wide4_q;
    end
  end

  assign done_o = vld_q[PIPE_LAT-1];
  assign res_o  = res_q;
  assign prod_o = prod_q;
endmodule

// File: rtl/gfm_karatsuba_mul_chk.sv
module gfm_karatsuba_mul_chk
  import gfm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [GF_W-1:0]   a_i,
  input logic [GF_W-1:0]   b_i,
  input logic              done_o,
  input logic [GF_W-1:0]   res_o,
  input logic [PROD_W-1:0] prod_o
);
  logic [PIPE_LAT-1:0] st_sh, zr_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_sh <= '0;
      zr_sh <= '0;
    end else begin
      st_sh <= {st_sh[PIPE_LAT-2:0], start_i};
      zr_sh <= {zr_sh[PIPE_LAT-2:0], start_i && (a_i == '0 || b_i == '0)};
    end
  end

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done_o == st_sh[PIPE_LAT-1]);

  assert_zero_operand_R6: assert property (@(posedge clk) disable iff (rst)
    zr_sh[PIPE_LAT-1] |-> (res_o == '0 && prod_o == '0));

  assert_prod_top_clear_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !prod_o[PROD_W-1]);

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(res_o) && $stable(prod_o)));
endmodule

bind gfm_karatsuba_mul gfm_karatsuba_mul_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .done_o (done_o),
  .res_o  (res_o),
  .prod_o (prod_o)
);

// File: tb/gfm_karatsuba_mul_tb_top.sv
module gfm_karatsuba_mul_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [127:0] a_i, b_i;
  logic         done_o;
  logic [127:0] res_o;
  logic [255:0] prod_o;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [127:0] X128_RES = 128'hC2000000_00000000_00000000_00000001;

  always #5 clk = ~clk;

  gfm_karatsuba_mul dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .done_o(done_o), .res_o(res_o), .prod_o(prod_o)
  );

  function automatic logic [255:0] ref_clmul(logic [127:0] a, logic [127:0] b);
    logic [255:0] t = '0;
    for (int i = 0; i < 128; i++)
      if (b[i]) t = t ^ ({128'b0, a} << i);
    return t;
  endfunction

  function automatic logic [127:0] ref_dot(logic [127:0] a, logic [127:0] b);
    logic [255:0] t = ref_clmul(a, b);
    logic [255:0] q = {127'b0, 1'b1, X128_RES};
    for (int i = 0; i < 128; i++) begin
      if (t[0]) t = t ^ q;
      t = t >> 1;
    end
    return t[127:0];
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // at a negedge: issue one operation, scramble inputs, check the done cycle
  task automatic run_one(logic [127:0] a, logic [127:0] b, logic [127:0] exp_res, string req);
    logic early = 1'b0;
    start_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k < 5; k++) begin
      if (done_o) early = 1'b1;
      a_i = rnd128(); b_i = rnd128();   // R2: ignored after the start cycle
      @(negedge clk);
    end
    chk("R3", "no early done", {255'b0, early}, 256'b0);
    chk("R3", "done at n+5", {255'b0, done_o}, 256'b1);
    chk(req, "result", {128'b0, res_o}, {128'b0, exp_res});
    chk("R4", "unreduced product", prod_o, ref_clmul(a, b));
    @(negedge clk);
    chk("R3", "done single pulse", {255'b0, done_o}, 256'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb, hold_res;
    logic [255:0] hold_prod;
    logic [127:0] qa [12];
    logic [127:0] qb [12];
    rst = 1'b1; start_i = 1'b0; a_i = '0; b_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", {255'b0, done_o}, 256'b0);
    chk("R1", "res after reset", {128'b0, res_o}, 256'b0);
    chk("R1", "prod after reset", prod_o, 256'b0);

    // R6: zero operands
    run_one(128'b0, rnd128(), 128'b0, "R6");
    run_one(rnd128(), 128'b0, 128'b0, "R6");
    run_one(128'b0, 128'b0, 128'b0, "R6");

    // R7: walking single bit against the residue of x^128
    for (int i = 0; i < 128; i++) begin
      ra = 128'b1 << i;
      run_one(ra, X128_RES, ra, "R7");
    end
    run_one({128{1'b1}}, X128_RES, {128{1'b1}}, "R7");

    // R5: random pairs and extremes, R2 via scrambled inputs in run_one
    run_one({128{1'b1}}, {128{1'b1}}, ref_dot({128{1'b1}}, {128{1'b1}}), "R5");
    for (int i = 0; i < 48; i++) begin
      ra = rnd128(); rb = rnd128();
      run_one(ra, rb, ref_dot(ra, rb), "R5");
    end

    // R9: outputs hold with no start while inputs move
    hold_res = res_o; hold_prod = prod_o;
    for (int k = 0; k < 8; k++) begin
      a_i = rnd128(); b_i = rnd128();
      @(negedge clk);
    end
    chk("R9", "res held", {128'b0, res_o}, {128'b0, hold_res});
    chk("R9", "prod held", prod_o, hold_prod);

    // R8: back-to-back issue
    for (int j = 0; j < 12; j++) begin
      qa[j] = rnd128(); qb[j] = rnd128();
    end
    for (int k = 0; k < 17; k++) begin
      if (k >= 5) begin
        chk("R8", "stream done", {255'b0, done_o}, 256'b1);
        chk("R8", "stream result", {128'b0, res_o}, {128'b0, ref_dot(qa[k-5], qb[k-5])});
        chk("R8", "stream product", prod_o, ref_clmul(qa[k-5], qb[k-5]));
      end
      if (k < 12) begin
        start_i = 1'b1; a_i = qa[k]; b_i = qb[k];
      end else begin
        start_i = 1'b0; a_i = rnd128(); b_i = rnd128();
      end
      @(negedge clk);
    end
    chk("R8", "stream ends", {255'b0, done_o}, 256'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule